// File: doc/BRIEF.md
# Timestamped Prefetch Release Buffer

This block sits between a lookahead engine that runs far ahead of the main thread and the memory system's prefetch port. The lookahead engine computes prefetch addresses much earlier than they are useful. It hands each address to this buffer together with a release timestamp, which is set about one memory latency before the estimated cycle at which the trailing core will run the matching load. Entries are held until a free-running cycle counter reaches their timestamp, and only then are they sent out as prefetches.

Some addresses could not be translated when they were inserted. Those entries keep their virtual address and are marked virtual. When such an entry comes due, the buffer sends the address to a translation port and waits for the answer. A good answer issues the prefetch with the returned physical address. A fault discards the entry. A flush input clears all stored state in one cycle, for example when the lookahead engine is restarted.

Top module: `pfb_release_buffer`

## Requirements
- R1: While reset is held, `now_o` is 0, `pf_valid_o` and `xlat_req_valid_o` are low, and `drop_count_o` is 0.
- R2: `now_o` rises by exactly 1 every clock cycle after reset, modulo 2^32.
- R3: An entry is due when `(now_o - ts) mod 2^32` is below 2^31. A due physical entry whose timestamp T was inserted while the counter read n issues on `pf_addr_o`. The issue appears in the cycle where `now_o = max(T, n+1) + 1`, provided nothing older competes.
- R4: At most one entry is selected per cycle. Among due entries the one with the oldest timestamp wins, and equal timestamps go to the lowest storage slot. Slots are filled lowest-free-first.
- R5: The due test is modular. A timestamp up to 2^31-1 behind the counter is already due, even when its numeric value is larger than the counter. A timestamp up to 2^31-1 ahead is not due.
- R6: A selected virtual entry raises `xlat_req_valid_o` for one cycle with its address on `xlat_req_vaddr_o`. This happens one cycle after selection. A non-faulting `xlat_rsp_valid_i` issues `xlat_rsp_paddr_i` on `pf_addr_o` in the following cycle.
- R7: A translation response with `xlat_rsp_fault_i` high issues nothing, and the entry is gone.
- R8: An insert that finds no free slot is not stored, and `drop_count_o` rises by 1 in the next cycle.
- R9: `flush_i` invalidates every entry and cancels a pending translation in one cycle. An insert in the same cycle is ignored and is not counted as a drop. The cycle after a flush shows no issue and no translation request.
- R10: `pf_valid_o` and `xlat_req_valid_o` are never high together. In a cycle where a translation response is accepted, no entry is selected.
- R11: Only one translation is outstanding at a time. Other virtual entries wait, while due physical entries keep issuing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_i | input | 1 | Invalidate all entries |
| ins_valid_i | input | 1 | Insert request |
| ins_addr_i | input | ADDR_W | Prefetch address to hold |
| ins_virt_i | input | 1 | 1: address is virtual, 0: physical |
| ins_time_i | input | 32 | Release timestamp |
| now_o | output | 32 | Free-running cycle counter |
| pf_valid_o | output | 1 | Prefetch issue strobe |
| pf_addr_o | output | ADDR_W | Physical prefetch address |
| xlat_req_valid_o | output | 1 | Translation request strobe |
| xlat_req_vaddr_o | output | ADDR_W | Virtual address to translate |
| xlat_rsp_valid_i | input | 1 | Translation response strobe |
| xlat_rsp_paddr_i | input | ADDR_W | Translated physical address |
| xlat_rsp_fault_i | input | 1 | Translation faulted |
| drop_count_o | output | CNT_W | Inserts dropped because the buffer was full |

## Verification
The insert register adds one cycle before an entry can be selected. Selection and issue add a second, so a physical prefetch shows up with `now_o` equal to `max(T, n+1) + 1`. A virtual entry shows its translation request at that same point, and its prefetch appears one cycle after the response is taken. The bench drives inputs on the falling edge and logs every issue and request together with the `now_o` value seen on the falling edge. Each check then compares the logged time against these formulas, rather than polling with slack. Drop counts and flush effects are read one falling edge after the clock edge that registers them.

// File: rtl/pfb_pkg.sv
package pfb_pkg;
    localparam int TS_W = 32;

    typedef logic [TS_W-1:0] stamp_t;

    // Modular age: how far the counter has passed the stamp.
    function automatic stamp_t stamp_age(input stamp_t now, input stamp_t ts);
        return now - ts;
    endfunction

    // Due when the age lies in the non-negative half of the circle.
    function automatic logic stamp_due(input stamp_t now, input stamp_t ts);
        stamp_t age;
        age = now - ts;
        return ~age[TS_W-1];
    endfunction
endpackage

// File: rtl/pfb_free_find.sv
module pfb_free_find #(
    parameter int DEPTH = 256,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0] vld_i,
    output logic             found_o,
    output logic [IW-1:0]    idx_o
);
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!vld_i[i]) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/pfb_due_pick.sv
module pfb_due_pick
    import pfb_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int IW    = $clog2(DEPTH)
) (
    input  stamp_t                      now_i,
    input  logic [DEPTH-1:0]            elig_i,
    input  logic [DEPTH-1:0][TS_W-1:0]  ts_i,
    output logic                        found_o,
    output logic [IW-1:0]               idx_o
);
    localparam int LEAVES = 1 << IW;
    localparam int NODES  = 2 * LEAVES - 1;

    logic            n_vld [NODES];
    logic [TS_W-1:0] n_age [NODES];
    logic [IW-1:0]   n_idx [NODES];

    for (genvar g = 0; g < LEAVES; g++) begin : g_leaf
        localparam int NODE = LEAVES - 1 + g;
        if (g < DEPTH) begin : g_real
            assign n_age[NODE] = stamp_age(now_i, ts_i[g]);
            assign n_vld[NODE] = elig_i[g] & stamp_due(now_i, ts_i[g]);
            assign n_idx[NODE] = IW'(g);
        end else begin : g_pad
            assign n_age[NODE] = '0;
            assign n_vld[NODE] = 1'b0;
            assign n_idx[NODE] = '0;
        end
    end

    // Right child wins only when strictly older, so ties keep the lower slot.
    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        logic take_r;
        assign take_r   = n_vld[2*n+2] &
                          (~n_vld[2*n+1] | (n_age[2*n+2] > n_age[2*n+1]));
        assign n_vld[n] = n_vld[2*n+1] | n_vld[2*n+2];
        assign n_age[n] = take_r ? n_age[2*n+2] : n_age[2*n+1];
        assign n_idx[n] = take_r ? n_idx[2*n+2] : n_idx[2*n+1];
    end

    assign found_o = n_vld[0];
    assign idx_o   = n_idx[0];
endmodule

// File: rtl/pfb_release_buffer.sv
module pfb_release_buffer
    import pfb_pkg::*;
#(
    parameter int DEPTH  = 256,
    parameter int ADDR_W = 48,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              ins_valid_i,
    input  logic [ADDR_W-1:0] ins_addr_i,
    input  logic              ins_virt_i,
    input  logic [31:0]       ins_time_i,
    output logic [31:0]       now_o,
    output logic              pf_valid_o,
    output logic [ADDR_W-1:0] pf_addr_o,
    output logic              xlat_req_valid_o,
    output logic [ADDR_W-1:0] xlat_req_vaddr_o,
    input  logic              xlat_rsp_valid_i,
    input  logic [ADDR_W-1:0] xlat_rsp_paddr_i,
    input  logic              xlat_rsp_fault_i,
    output logic [CNT_W-1:0]  drop_count_o
);
    localparam int IW = $clog2(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0]             vld;
        logic [DEPTH-1:0]             virt;
        logic [DEPTH-1:0][ADDR_W-1:0] addr;
        logic [DEPTH-1:0][TS_W-1:0]   ts;
        stamp_t                       now;
        logic                         xl_busy;
        logic                         pf_vld;
        logic [ADDR_W-1:0]            pf_addr;
        logic                         xreq_vld;
        logic [ADDR_W-1:0]            xreq_addr;
        logic [CNT_W-1:0]             drops;
    } state_t;

    state_t state_d, state_q;

    logic [DEPTH-1:0] elig;
    logic             pick_found;
    logic [IW-1:0]    pick_idx;
    logic             free_found;
    logic [IW-1:0]    free_idx;
    logic             rsp_take;

    // Virtual entries may only be picked while no translation is in flight.
    assign elig     = state_q.vld & (~state_q.virt | {DEPTH{~state_q.xl_busy}});
    assign rsp_take = state_q.xl_busy & xlat_rsp_valid_i;

    pfb_due_pick #(.DEPTH(DEPTH), .IW(IW)) u_pick (
        .now_i   (state_q.now),
        .elig_i  (elig),
        .ts_i    (state_q.ts),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    pfb_free_find #(.DEPTH(DEPTH), .IW(IW)) u_free (
        .vld_i   (state_q.vld),
        .found_o (free_found),
        .idx_o   (free_idx)
    );

    always_comb begin
        state_d          = state_q;
        state_d.now      = state_q.now + TS_W'(1);
        state_d.pf_vld   = 1'b0;
        state_d.xreq_vld = 1'b0;

        if (rsp_take) begin
            state_d.xl_busy = 1'b0;
            if (!xlat_rsp_fault_i) begin
                state_d.pf_vld  = 1'b1;
                state_d.pf_addr = xlat_rsp_paddr_i;
            end
        end else if (pick_found) begin
            state_d.vld[pick_idx] = 1'b0;
            if (state_q.virt[pick_idx]) begin
                state_d.xreq_vld  = 1'b1;
                state_d.xreq_addr = state_q.addr[pick_idx];
                state_d.xl_busy   = 1'b1;
            end else begin
                state_d.pf_vld  = 1'b1;
                state_d.pf_addr = state_q.addr[pick_idx];
            end
        end

        if (ins_valid_i && !flush_i) begin
            if (free_found) begin
                state_d.vld[free_idx]  = 1'b1;
                state_d.virt[free_idx] = ins_virt_i;
                state_d.addr[free_idx] = ins_addr_i;
                state_d.ts[free_idx]   = ins_time_i;
            end else begin
                state_d.drops = state_q.drops + CNT_W'(1);
            end
        end

        if (flush_i) begin
            state_d.vld      = '0;
            state_d.xl_busy  = 1'b0;
            state_d.pf_vld   = 1'b0;
            state_d.xreq_vld = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign now_o            = state_q.now;
    assign pf_valid_o       = state_q.pf_vld;
    assign pf_addr_o        = state_q.pf_addr;
    assign xlat_req_valid_o = state_q.xreq_vld;
    assign xlat_req_vaddr_o = state_q.xreq_addr;
    assign drop_count_o     = state_q.drops;
endmodule

// File: rtl/pfb_release_buffer_chk.sv
module pfb_release_buffer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             flush_i,
    input logic             xlat_rsp_valid_i,
    input logic             xlat_rsp_fault_i,
    input logic             busy_i,
    input logic             pf_valid_o,
    input logic             xlat_req_valid_o,
    input logic [31:0]      now_o,
    input logic [CNT_W-1:0] drop_count_o
);
    assert_counter_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> now_o == $past(now_o) + 32'd1);

    assert_fault_silent_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && xlat_rsp_valid_i && xlat_rsp_fault_i) |=> !pf_valid_o);

    assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (drop_count_o == $past(drop_count_o)) ||
                 (drop_count_o == $past(drop_count_o) + CNT_W'(1)));

    assert_flush_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> !pf_valid_o && !xlat_req_valid_o);

    assert_one_action_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(pf_valid_o && xlat_req_valid_o));

    assert_single_xlat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_req_valid_o |=> !xlat_req_valid_o);
endmodule

bind pfb_release_buffer pfb_release_buffer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .flush_i          (flush_i),
    .xlat_rsp_valid_i (xlat_rsp_valid_i),
    .xlat_rsp_fault_i (xlat_rsp_fault_i),
    .busy_i           (state_q.xl_busy),
    .pf_valid_o       (pf_valid_o),
    .xlat_req_valid_o (xlat_req_valid_o),
    .now_o            (now_o),
    .drop_count_o     (drop_count_o)
);

// File: tb/pfb_release_buffer_tb.sv
module pfb_release_buffer_tb;
    localparam int DEPTH = 8;
    localparam int AW    = 48;
    localparam int CW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          flush_i = 1'b0;
    logic          ins_valid_i = 1'b0;
    logic [AW-1:0] ins_addr_i = '0;
    logic          ins_virt_i = 1'b0;
    logic [31:0]   ins_time_i = '0;
    logic [31:0]   now_o;
    logic          pf_valid_o;
    logic [AW-1:0] pf_addr_o;
    logic          xlat_req_valid_o;
    logic [AW-1:0] xlat_req_vaddr_o;
    logic          xlat_rsp_valid_i = 1'b0;
    logic [AW-1:0] xlat_rsp_paddr_i = '0;
    logic          xlat_rsp_fault_i = 1'b0;
    logic [CW-1:0] drop_count_o;

    always #2 clk = ~clk;

    pfb_release_buffer #(.DEPTH(DEPTH), .ADDR_W(AW), .CNT_W(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .ins_valid_i(ins_valid_i), .ins_addr_i(ins_addr_i),
        .ins_virt_i(ins_virt_i), .ins_time_i(ins_time_i),
        .now_o(now_o), .pf_valid_o(pf_valid_o), .pf_addr_o(pf_addr_o),
        .xlat_req_valid_o(xlat_req_valid_o), .xlat_req_vaddr_o(xlat_req_vaddr_o),
        .xlat_rsp_valid_i(xlat_rsp_valid_i), .xlat_rsp_paddr_i(xlat_rsp_paddr_i),
        .xlat_rsp_fault_i(xlat_rsp_fault_i), .drop_count_o(drop_count_o)
    );

    int errors = 0;
    int checks = 0;

    logic [AW-1:0] pf_a [64];
    logic [31:0]   pf_t [64];
    logic [AW-1:0] xr_a [64];
    logic [31:0]   xr_t [64];
    int pf_n = 0;
    int xr_n = 0;
    int both_n = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (pf_valid_o && pf_n < 64) begin
                pf_a[pf_n] = pf_addr_o; pf_t[pf_n] = now_o; pf_n++;
            end
            if (xlat_req_valid_o && xr_n < 64) begin
                xr_a[xr_n] = xlat_req_vaddr_o; xr_t[xr_n] = now_o; xr_n++;
            end
            if (pf_valid_o && xlat_req_valid_o) both_n++;
        end
    end

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_log();
        pf_n = 0; xr_n = 0;
    endtask

    task automatic insert(input logic [AW-1:0] a, input bit v, input logic [31:0] ts, output logic [31:0] n);
        ins_valid_i = 1'b1; ins_addr_i = a; ins_virt_i = v; ins_time_i = ts;
        n = now_o;
        @(negedge clk);
        ins_valid_i = 1'b0;
    endtask

    task automatic wait_now(input logic [31:0] t);
        while (now_o != t) @(negedge clk);
    endtask

    task automatic do_flush();
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] a;
        repeat (3) @(negedge clk);
        check(now_o == 0, "R1 counter in reset", 64'(now_o), 0);
        check(!pf_valid_o && !xlat_req_valid_o, "R1 strobes in reset", 64'({pf_valid_o, xlat_req_valid_o}), 0);
        check(drop_count_o == 0, "R1 drop count in reset", 64'(drop_count_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        a = now_o;
        repeat (7) @(negedge clk);
        check(now_o == a + 7, "R2 counter step", 64'(now_o), 64'(a + 7));
    endtask

    task automatic t_due();
        logic [31:0] n, n2;
        clear_log();
        insert(48'hA000, 1'b0, now_o + 20, n);
        insert(48'hB000, 1'b0, now_o - 5, n2);
        wait_now(n + 30);
        check(pf_n == 2, "R3 issue count", 64'(pf_n), 2);
        check(pf_a[0] == 48'hB000 && pf_t[0] == n2 + 2, "R3 past stamp timing", 64'(pf_t[0]), 64'(n2 + 2));
        check(pf_a[1] == 48'hA000 && pf_t[1] == n + 21, "R3 future stamp timing", 64'(pf_t[1]), 64'(n + 21));
    endtask

    task automatic t_order();
        logic [31:0] n, x, dummy;
        logic [AW-1:0] exp_a [5];
        clear_log();
        n = now_o;
        x = n + 20;
        for (int i = 0; i < 4; i++) insert(48'h100 + 48'(i), 1'b0, x, dummy);
        wait_now(x);
        insert(48'hE00, 1'b0, 32'd0, dummy);
        wait_now(x + 10);
        exp_a = '{48'h100, 48'hE00, 48'h101, 48'h102, 48'h103};
        check(pf_n == 5, "R4 issue count", 64'(pf_n), 5);
        for (int i = 0; i < 5; i++)
            check(pf_a[i] == exp_a[i] && pf_t[i] == x + 1 + 32'(i), "R4 oldest-first order",
                  64'(pf_a[i]), 64'(exp_a[i]));
    endtask

    task automatic t_wrap();
        logic [31:0] n, d;
        clear_log();
        insert(48'hC0DE, 1'b0, now_o - 32'h0000_1000, n);
        insert(48'hF00D, 1'b0, now_o + 32'h7000_0000, d);
        wait_now(n + 40);
        check(pf_n == 1, "R5 only wrapped-past stamp issues", 64'(pf_n), 1);
        check(pf_a[0] == 48'hC0DE && pf_t[0] == n + 2, "R5 wrapped stamp due at once", 64'(pf_t[0]), 64'(n + 2));
        do_flush();
    endtask

    task automatic t_flush();
        logic [31:0] n, d;
        clear_log();
        insert(48'h7100, 1'b0, now_o + 10, n);
        insert(48'h7200, 1'b0, n + 10, d);
        insert(48'h7300, 1'b1, n + 10, d);
        wait_now(n + 5);
        flush_i = 1'b1;
        ins_valid_i = 1'b1; ins_addr_i = 48'h7400; ins_virt_i = 1'b0; ins_time_i = n - 3;
        @(negedge clk);
        flush_i = 1'b0; ins_valid_i = 1'b0;
        wait_now(n + 40);
        check(pf_n == 0 && xr_n == 0, "R9 flushed entries never issue", 64'(pf_n + xr_n), 0);
        check(drop_count_o == 0, "R9 insert during flush not a drop", 64'(drop_count_o), 0);
        insert(48'h7500, 1'b0, now_o - 1, n);
        wait_now(n + 5);
        check(pf_n == 1 && pf_a[0] == 48'h7500, "R9 buffer usable after flush", 64'(pf_a[0]), 48'h7500);
    endtask

    task automatic t_virt();
        logic [31:0] n, d;
        clear_log();
        insert(48'hAAA0, 1'b1, now_o + 8, n);
        insert(48'hBBB0, 1'b1, n + 8, d);
        insert(48'hCCC0, 1'b0, n + 9, d);
        insert(48'hDDD0, 1'b0, n + 14, d);
        wait_now(n + 14);
        xlat_rsp_valid_i = 1'b1; xlat_rsp_paddr_i = 48'h5550; xlat_rsp_fault_i = 1'b0;
        @(negedge clk);
        xlat_rsp_valid_i = 1'b0;
        wait_now(n + 20);
        xlat_rsp_valid_i = 1'b1; xlat_rsp_paddr_i = 48'h6660; xlat_rsp_fault_i = 1'b1;
        @(negedge clk);
        xlat_rsp_valid_i = 1'b0; xlat_rsp_fault_i = 1'b0;
        wait_now(n + 35);
        check(xr_n == 2, "R11 two translation requests", 64'(xr_n), 2);
        check(xr_a[0] == 48'hAAA0 && xr_t[0] == n + 9, "R6 first request", 64'(xr_t[0]), 64'(n + 9));
        check(xr_a[1] == 48'hBBB0 && xr_t[1] == n + 16, "R11 second virtual waits for response", 64'(xr_t[1]), 64'(n + 16));
        check(pf_n == 3, "R7 faulted entry not issued", 64'(pf_n), 3);
        check(pf_a[0] == 48'hCCC0 && pf_t[0] == n + 10, "R11 physical issues while translating", 64'(pf_t[0]), 64'(n + 10));
        check(pf_a[1] == 48'h5550 && pf_t[1] == n + 15, "R6 translated address issued", 64'(pf_a[1]), 48'h5550);
        check(pf_a[2] == 48'hDDD0 && pf_t[2] == n + 17, "R10 response blocks selection", 64'(pf_t[2]), 64'(n + 17));
        check(both_n == 0, "R10 never issue and request together", 64'(both_n), 0);
    endtask

    task automatic t_full();
        logic [31:0] n, d;
        logic [CW-1:0] d0;
        clear_log();
        d0 = drop_count_o;
        n = now_o;
        for (int i = 0; i < DEPTH; i++) insert(48'h900 + 48'(i), 1'b0, n + 30, d);
        insert(48'hBAD0, 1'b0, now_o - 2, d);
        insert(48'hBAD1, 1'b0, now_o - 2, d);
        check(drop_count_o == d0 + 2, "R8 drop count", 64'(drop_count_o), 64'(d0 + 2));
        wait_now(n + 50);
        check(pf_n == DEPTH, "R8 dropped inserts not stored", 64'(pf_n), 64'(DEPTH));
        for (int i = 0; i < DEPTH; i++)
            check(pf_a[i] == 48'h900 + 48'(i) && pf_t[i] == n + 31 + 32'(i), "R4 tie order lowest slot",
                  64'(pf_a[i]), 64'(48'h900 + 48'(i)));
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_due();
        t_order();
        t_wrap();
        t_flush();
        t_virt();
        t_full();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule